// File: doc/BRIEF.md
# Buffered Request and Data Link

A point-to-point connection between one master port and one slave port that share a clock. Every link has a request channel. Each request word carries a one-bit command, a destination address, a transfer length and a free-form option field whose meaning the two endpoints agree on. Two data channels are optional and are each switched on by their own parameter: a write-data channel from master to slave and a read-data channel from slave to master. Each channel has its own synchronous FIFO, and each FIFO depth is a separate parameter.

On the way through the link the request address is resized from the master width to the slave width. A fixed design-time offset is then added to it. This lets several masters reach private regions of one slave without knowing where those regions sit. Producers see a full flag and a push strobe. Consumers see an empty flag and a pop strobe. Every FIFO is show-ahead: the head entry is already on the data outputs whenever empty is low.

Top module: `chan_link`

## Requirements
- R1: After reset every channel is empty: `s_req_empty`, `s_wempty` and `m_rempty` are 1, and `m_req_full`, `m_wfull` and `s_rfull` are 0.
- R2: Requests leave the slave side in the order they were accepted. The command (0 = read, 1 = write), size and option fields arrive unchanged.
- R3: The slave-side address is the low `SADDR_W` bits of the master address plus `ADDR_OFS`, taken modulo 2^`SADDR_W`. The master address is zero-extended first if it is narrower than `SADDR_W`.
- R4: A channel reports full once it holds its configured depth of entries. A push while full is ignored and does not disturb the entries already stored.
- R5: The head entry is visible whenever empty is low, and a pop removes it. A pop while empty is ignored, and an entry pushed into an empty FIFO is visible on the next cycle.
- R6: The write-data channel (`HAS_WR` = 1) delivers master words to the slave in order, with depth `WD_DEPTH`.
- R7: The read-data channel (`HAS_RD` = 1) delivers slave words to the master in order, with depth `RD_DEPTH`.
- R8: A disabled data channel stores nothing. Its producer side reports full and its consumer side reports empty at all times.
- R9: A push that arrives in the same cycle as a pop on a full FIFO is refused. The entry count drops by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_req_push | input | 1 | Master request push strobe |
| m_req_cmd | input | 1 | Command, 0 read, 1 write |
| m_req_addr | input | MADDR_W | Master-side address |
| m_req_size | input | SIZE_W | Length in 32-bit words |
| m_req_opt | input | OPT_W | User-defined option bits |
| m_req_full | output | 1 | Request FIFO full (master must wait) |
| s_req_pop | input | 1 | Slave request pop strobe |
| s_req_empty | output | 1 | Request FIFO empty |
| s_req_cmd | output | 1 | Head command |
| s_req_addr | output | SADDR_W | Head address, relocated |
| s_req_size | output | SIZE_W | Head size |
| s_req_opt | output | OPT_W | Head option bits |
| m_wpush | input | 1 | Write-data push strobe |
| m_wdata | input | DATA_W | Write data from master |
| m_wfull | output | 1 | Write-data FIFO full |
| s_wpop | input | 1 | Write-data pop strobe |
| s_wempty | output | 1 | Write-data FIFO empty |
| s_wdata | output | DATA_W | Head write data |
| s_rpush | input | 1 | Read-data push strobe |
| s_rdata | input | DATA_W | Read data from slave |
| s_rfull | output | 1 | Read-data FIFO full |
| m_rpop | input | 1 | Read-data pop strobe |
| m_rempty | output | 1 | Read-data FIFO empty |
| m_rdata | output | DATA_W | Head read data |

## Verification
The main instance is built with a 16-bit master address and a 12-bit slave address, so the upper master bits are dropped. Its offset of 0xF00 makes the address sum wrap for many inputs. The request and write-data FIFOs are four deep and the read-data FIFO is two deep, so each channel has its own full point and the full, refused-push and push-during-pop cases are reached within a few cycles. A second instance with both data channels disabled shares the same stimulus, which shows that data pushed into a disabled channel never appears anywhere.

// File: rtl/chan_link.sv
module chan_link_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  wire do_push = push && !full;
  wire do_pop  = pop && !empty;

  assign full  = (cnt == (AW+1)'(DEPTH));
  assign empty = (cnt == '0);
  assign dout  = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  always_ff @(posedge clk)
    if (do_push) mem[wp] <= din;
endmodule

module chan_link #(
  parameter int                MADDR_W   = 16,
  parameter int                SADDR_W   = 12,
  parameter logic [SADDR_W-1:0] ADDR_OFS = 'hF00,
  parameter int                SIZE_W    = 8,
  parameter int                OPT_W     = 4,
  parameter int                DATA_W    = 32,
  parameter bit                HAS_WR    = 1'b1,
  parameter bit                HAS_RD    = 1'b1,
  parameter int                REQ_DEPTH = 4,
  parameter int                WD_DEPTH  = 4,
  parameter int                RD_DEPTH  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               m_req_push,
  input  logic               m_req_cmd,
  input  logic [MADDR_W-1:0] m_req_addr,
  input  logic [SIZE_W-1:0]  m_req_size,
  input  logic [OPT_W-1:0]   m_req_opt,
  output logic               m_req_full,
  input  logic               s_req_pop,
  output logic               s_req_empty,
  output logic               s_req_cmd,
  output logic [SADDR_W-1:0] s_req_addr,
  output logic [SIZE_W-1:0]  s_req_size,
  output logic [OPT_W-1:0]   s_req_opt,
  input  logic               m_wpush,
  input  logic [DATA_W-1:0]  m_wdata,
  output logic               m_wfull,
  input  logic               s_wpop,
  output logic               s_wempty,
  output logic [DATA_W-1:0]  s_wdata,
  input  logic               s_rpush,
  input  logic [DATA_W-1:0]  s_rdata,
  output logic               s_rfull,
  input  logic               m_rpop,
  output logic               m_rempty,
  output logic [DATA_W-1:0]  m_rdata
);
  localparam int REQ_W = 1 + SADDR_W + SIZE_W + OPT_W;

  logic [SADDR_W-1:0] addr_rs;
  logic [REQ_W-1:0]   req_in, req_out;

  generate
    if (MADDR_W > SADDR_W) begin : g_trunc
      assign addr_rs = m_req_addr[SADDR_W-1:0];
      wire unused_hi = &{1'b0, m_req_addr[MADDR_W-1:SADDR_W]};
    end else begin : g_ext
      assign addr_rs = SADDR_W'(m_req_addr);
    end
  endgenerate

  assign req_in = {m_req_cmd, addr_rs + ADDR_OFS, m_req_size, m_req_opt};
  assign {s_req_cmd, s_req_addr, s_req_size, s_req_opt} = req_out;

  chan_link_fifo #(.W(REQ_W), .DEPTH(REQ_DEPTH)) u_req (
    .clk, .rst_n, .push(m_req_push), .din(req_in), .full(m_req_full),
    .pop(s_req_pop), .dout(req_out), .empty(s_req_empty));

  generate
    if (HAS_WR) begin : g_wr
      chan_link_fifo #(.W(DATA_W), .DEPTH(WD_DEPTH)) u_wd (
        .clk, .rst_n, .push(m_wpush), .din(m_wdata), .full(m_wfull),
        .pop(s_wpop), .dout(s_wdata), .empty(s_wempty));
    end else begin : g_no_wr
      assign m_wfull  = 1'b1;
      assign s_wempty = 1'b1;
      assign s_wdata  = '0;
      wire unused_wr = &{1'b0, m_wpush, m_wdata, s_wpop};
    end

    if (HAS_RD) begin : g_rd
      chan_link_fifo #(.W(DATA_W), .DEPTH(RD_DEPTH)) u_rd (
        .clk, .rst_n, .push(s_rpush), .din(s_rdata), .full(s_rfull),
        .pop(m_rpop), .dout(m_rdata), .empty(m_rempty));
    end else begin : g_no_rd
      assign s_rfull  = 1'b1;
      assign m_rempty = 1'b1;
      assign m_rdata  = '0;
      wire unused_rd = &{1'b0, s_rpush, s_rdata, m_rpop};
    end
  endgenerate
endmodule

module chan_link_chk #(
  parameter int SADDR_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               m_req_push,
  input logic               m_req_full,
  input logic               s_req_pop,
  input logic               s_req_empty,
  input logic               s_req_cmd,
  input logic [SADDR_W-1:0] s_req_addr,
  input logic               m_wfull,
  input logic               s_wpop,
  input logic               s_rfull,
  input logic               m_rpop
);
  p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> s_req_empty && !m_req_full);

  p_head_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !s_req_empty && !s_req_pop |=> $stable(s_req_addr) && $stable(s_req_cmd));

  p_full_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    m_req_full && !s_req_pop |=> m_req_full);

  p_no_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_req_full && s_req_empty));

  p_empty_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    s_req_empty && !m_req_push |=> s_req_empty);

  p_push_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    s_req_empty && m_req_push |=> !s_req_empty);

  p_wr_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    m_wfull && !s_wpop |=> m_wfull);

  p_rd_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    s_rfull && !m_rpop |=> s_rfull);
endmodule

bind chan_link chan_link_chk #(.SADDR_W(SADDR_W)) u_chk (
  .clk, .rst_n, .m_req_push, .m_req_full, .s_req_pop, .s_req_empty,
  .s_req_cmd, .s_req_addr, .m_wfull, .s_wpop, .s_rfull, .m_rpop);

// File: tb/tb_chan_link.sv
module tb_chan_link;
  localparam int MA = 16, SA = 12, SZ = 8, OP = 4, DW = 32;
  localparam logic [SA-1:0] OFS = 12'hF00;
  localparam int RQW = 1 + SA + SZ + OP;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic m_req_push = 0, m_req_cmd = 0, s_req_pop = 0;
  logic [MA-1:0] m_req_addr = '0;
  logic [SZ-1:0] m_req_size = '0;
  logic [OP-1:0] m_req_opt = '0;
  logic m_req_full, s_req_empty, s_req_cmd;
  logic [SA-1:0] s_req_addr;
  logic [SZ-1:0] s_req_size;
  logic [OP-1:0] s_req_opt;
  logic m_wpush = 0, s_wpop = 0, s_rpush = 0, m_rpop = 0;
  logic [DW-1:0] m_wdata = '0, s_rdata = '0;
  logic m_wfull, s_wempty, s_rfull, m_rempty;
  logic [DW-1:0] s_wdata, m_rdata;

  logic n_req_full, n_req_empty, n_req_cmd, n_wfull, n_wempty, n_rfull, n_rempty;
  logic [SA-1:0] n_req_addr;
  logic [SZ-1:0] n_req_size;
  logic [OP-1:0] n_req_opt;
  logic [DW-1:0] n_wdata, n_rdata;

  chan_link #(.MADDR_W(MA), .SADDR_W(SA), .ADDR_OFS(OFS), .SIZE_W(SZ), .OPT_W(OP),
    .DATA_W(DW), .HAS_WR(1'b1), .HAS_RD(1'b1), .REQ_DEPTH(4), .WD_DEPTH(4), .RD_DEPTH(2)) dut (
    .clk, .rst_n, .m_req_push, .m_req_cmd, .m_req_addr, .m_req_size, .m_req_opt,
    .m_req_full, .s_req_pop, .s_req_empty, .s_req_cmd, .s_req_addr, .s_req_size,
    .s_req_opt, .m_wpush, .m_wdata, .m_wfull, .s_wpop, .s_wempty, .s_wdata,
    .s_rpush, .s_rdata, .s_rfull, .m_rpop, .m_rempty, .m_rdata);

  chan_link #(.MADDR_W(MA), .SADDR_W(SA), .ADDR_OFS(OFS), .SIZE_W(SZ), .OPT_W(OP),
    .DATA_W(DW), .HAS_WR(1'b0), .HAS_RD(1'b0), .REQ_DEPTH(4), .WD_DEPTH(4), .RD_DEPTH(2)) dut_nodata (
    .clk, .rst_n, .m_req_push, .m_req_cmd, .m_req_addr, .m_req_size, .m_req_opt,
    .m_req_full(n_req_full), .s_req_pop(1'b1), .s_req_empty(n_req_empty),
    .s_req_cmd(n_req_cmd), .s_req_addr(n_req_addr), .s_req_size(n_req_size),
    .s_req_opt(n_req_opt), .m_wpush, .m_wdata, .m_wfull(n_wfull), .s_wpop,
    .s_wempty(n_wempty), .s_wdata(n_wdata), .s_rpush, .s_rdata, .s_rfull(n_rfull),
    .m_rpop, .m_rempty(n_rempty), .m_rdata(n_rdata));

  int checks = 0, fails = 0, req_pops = 0, wd_pops = 0, rd_pops = 0;
  logic [RQW-1:0] req_q[$];
  logic [DW-1:0]  wd_q[$], rd_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [SA-1:0] reloc(input logic [MA-1:0] a);
    return SA'(a[SA-1:0] + OFS);
  endfunction

  // scoreboard: accepted pushes become expected items
  always @(posedge clk) if (rst_n) begin
    if (m_req_push && !m_req_full)
      req_q.push_back({m_req_cmd, reloc(m_req_addr), m_req_size, m_req_opt});
    if (m_wpush && !m_wfull) wd_q.push_back(m_wdata);
    if (s_rpush && !s_rfull) rd_q.push_back(s_rdata);
  end

  // monitor: every pop is compared with the oldest expected item
  always @(posedge clk) if (rst_n) begin
    if (s_req_pop && !s_req_empty) begin
      logic [RQW-1:0] e;
      req_pops++;
      e = (req_q.size() > 0) ? req_q.pop_front() : '1;
      chk("R2 cmd", 32'(s_req_cmd), 32'(e[RQW-1]));
      chk("R3 addr", 32'(s_req_addr), 32'(e[RQW-2 -: SA]));
      chk("R2 size/opt", 32'({s_req_size, s_req_opt}), 32'(e[SZ+OP-1:0]));
    end
    if (s_wpop && !s_wempty) begin
      wd_pops++;
      chk("R6 wdata", s_wdata, (wd_q.size() > 0) ? wd_q.pop_front() : 32'hDEAD_DEAD);
    end
    if (m_rpop && !m_rempty) begin
      rd_pops++;
      chk("R7 rdata", m_rdata, (rd_q.size() > 0) ? rd_q.pop_front() : 32'hDEAD_DEAD);
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic put_req(input logic c, input logic [MA-1:0] a, input logic [SZ-1:0] s,
                         input logic [OP-1:0] o);
    m_req_push = 1; m_req_cmd = c; m_req_addr = a; m_req_size = s; m_req_opt = o;
    tick();
    m_req_push = 0;
  endtask

  task automatic drain_req(output int n);
    int start = req_pops;
    s_req_pop = 1;
    for (int i = 0; i < 8; i++) tick();
    s_req_pop = 0;
    n = req_pops - start;
  endtask

  int n;

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R1 req empty", 32'(s_req_empty), 1);
    chk("R1 req full", 32'(m_req_full), 0);
    chk("R1 wd empty/full", 32'({s_wempty, m_wfull}), 32'b10);
    chk("R1 rd empty/full", 32'({m_rempty, s_rfull}), 32'b10);

    // R2/R3: mixed fields, address wrap and upper-bit truncation
    put_req(1'b1, 16'h0123, 8'd4, 4'h3);
    put_req(1'b0, 16'hABCD, 8'd1, 4'hA);
    put_req(1'b1, 16'h00FF, 8'd255, 4'hF);
    drain_req(n);
    chk("R2 three requests delivered", n, 3);

    // R4: fill, push while full is ignored
    for (int i = 0; i < 4; i++) put_req(i[0], 16'h1000 + 16'(i), 8'(i + 1), 4'(i));
    chk("R4 full at depth", 32'(m_req_full), 1);
    put_req(1'b1, 16'h0777, 8'd9, 4'h9);
    chk("R4 still full after refused push", 32'(m_req_full), 1);
    drain_req(n);
    chk("R4 only stored entries drained", n, 4);

    // R9: push and pop together while full
    for (int i = 0; i < 4; i++) put_req(1'b0, 16'h2200 + 16'(i), 8'd7, 4'h1);
    m_req_push = 1; m_req_addr = 16'h0555; s_req_pop = 1;
    tick();
    m_req_push = 0; s_req_pop = 0;
    chk("R9 not full after pop with refused push", 32'(m_req_full), 0);
    drain_req(n);
    chk("R9 three remain", n, 3);

    // R5: pop on empty ignored; show-ahead head
    s_req_pop = 1; tick(); tick(); s_req_pop = 0;
    chk("R5 empty after idle pops", 32'(s_req_empty), 1);
    put_req(1'b1, 16'h0042, 8'd33, 4'h5);
    chk("R5 visible next cycle", 32'(s_req_empty), 0);
    chk("R5 head size without pop", 32'(s_req_size), 33);
    chk("R3 head addr without pop", 32'(s_req_addr), 32'(reloc(16'h0042)));
    drain_req(n);
    chk("R5 one popped", n, 1);

    // R6 write channel; R8 disabled copy
    for (int i = 0; i < 6; i++) begin
      m_wpush = 1; m_wdata = 32'hA000_0000 + 32'(i); tick();
    end
    m_wpush = 0;
    chk("R6 write full", 32'(m_wfull), 1);
    chk("R8 disabled write full/empty", 32'({n_wfull, n_wempty}), 32'b11);
    s_wpop = 1; for (int i = 0; i < 6; i++) tick(); s_wpop = 0;
    chk("R6 four words delivered", wd_pops, 4);

    // R7 read channel, depth 2; R8 disabled copy
    for (int i = 0; i < 3; i++) begin
      s_rpush = 1; s_rdata = 32'h5000_0000 + 32'(i * 3); tick();
    end
    s_rpush = 0;
    chk("R7 read full at 2", 32'(s_rfull), 1);
    chk("R8 disabled read full/empty", 32'({n_rfull, n_rempty}), 32'b11);
    m_rpop = 1; for (int i = 0; i < 4; i++) tick(); m_rpop = 0;
    chk("R7 two words delivered", rd_pops, 2);
    chk("R8 disabled data stays zero", n_wdata | n_rdata, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule